// File: doc/BRIEF.md
# Partitioned SIMD Integer Multiplier

This block multiplies two 64-bit operands that are split into packed integer lanes. A set of cut flags, one at each byte boundary inside the word, splits the operands into contiguous lanes of whole bytes. The usual configurations are eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane, and mixed splits also work. Every lane of `opA` is multiplied by the lane of `opB` at the same bit positions. All lane widths share one array of byte-by-byte partial products. Lanes are kept apart only by choosing which partial products and which carries take part.

Each lane has a 2-bit operation code. The code selects either the low half of the lane product, or the high half with both operands signed, `opA` signed and `opB` unsigned, or both unsigned. The block has two outputs. `prodOut` packs one w-bit result per lane into the positions of that lane's operands. `wideOut` holds the full 2w-bit product of every lane, placed at twice the lane's bit offset.

A parameter sets a number of register levels between the product array and the output selection. The lane control for the selection is delayed by the same number of cycles. With zero levels both outputs follow the inputs combinationally.

Top module: `simd_part_mul`

## Requirements
- R1: Bit j of `laneCuts` (j = 0..6) places a lane boundary between byte j and byte j+1, which is bit position 8j+8. A lane covers the bytes between two neighbouring boundaries or word ends. A lane of width w starting at bit s uses bits s..s+w-1 of each operand.
- R2: `wideOut` bits 2s..2s+2w-1 hold the lane product truncated to 2w bits. A low-half code treats both lane operands as signed for this product. A high-half code uses the signedness given by its code.
- R3: Operation code 0 (low half) puts product bits 0..w-1 on `prodOut` bits s..s+w-1.
- R4: Operation code 1 puts product bits w..2w-1 on `prodOut` bits s..s+w-1, with both lane operands taken as two's-complement signed.
- R5: Operation code 2 puts the high half on `prodOut`, with the `opA` lane signed and the `opB` lane unsigned.
- R6: Operation code 3 puts the high half on `prodOut`, with both lane operands unsigned.
- R7: `laneOps` bits 2m+1..2m hold the code for byte m. A lane obeys only the code of its lowest byte, and the codes of its other bytes have no effect on either output.
- R8: With `PIPE_STAGES` = 0, both outputs are combinational functions of the present inputs.
- R9: With `PIPE_STAGES` = N > 0, both outputs show the result of the inputs sampled N rising edges earlier. This holds while the inputs change on every cycle, because the lane control is delayed with the data.
- R10: While `rst_n` is low, with `PIPE_STAGES` > 0, both outputs are zero whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register levels |
| rst_n | input | 1 | Asynchronous active-low reset of the register levels |
| opA | input | 64 | First packed operand (multiplicand) |
| opB | input | 64 | Second packed operand (multiplier) |
| laneCuts | input | 7 | Lane boundary flags, bit j between byte j and byte j+1 |
| laneOps | input | 16 | 2-bit operation code per byte, lowest byte of each lane is used |
| prodOut | output | 64 | Packed per-lane w-bit results |
| wideOut | output | 128 | Full 2w-bit product of every lane at offset 2s |

## Verification
A wrong lane decode or a carry that leaks across a field boundary corrupts neighbouring lanes. It shows at `wideOut` in the cycle the vector is applied, or N edges later with N levels. The sweep covers every one of the 128 cut patterns under each code, and each pattern gets operands with set sign bits, so any such leak would be seen. If the lane control went out of step with the delayed products, the high half would be taken from the wrong operation. Operation codes change on every cycle during the run, so this shows as a `prodOut` mismatch on the first vector where two neighbouring operations differ. Stale register contents left by reset would show at the outputs during reset and on the first outputs after it.

// File: rtl/simd_part_mul_pkg.sv
package simd_part_mul_pkg;

  localparam int BYTE_W     = 8;
  localparam int LANE_SLOTS = 8;
  localparam int DATA_W     = BYTE_W * LANE_SLOTS;
  localparam int WIDE_W     = 2 * DATA_W;
  localparam int WIDE_SLOTS = 2 * LANE_SLOTS;
  localparam int IDX_W      = $clog2(LANE_SLOTS);
  localparam int OP_W       = 2;
  localparam int PROD_W     = 2 * BYTE_W;

  typedef enum logic [OP_W-1:0] {
    OP_LOW   = 2'd0,
    OP_HI_SS = 2'd1,
    OP_HI_SU = 2'd2,
    OP_HI_UU = 2'd3
  } laneOp_e;

  // strobes the array needs for one byte slot
  typedef struct packed {
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
    logic             aSgn;
    logic             bSgn;
  } arrCtl_t;

  // strobes the output selection needs for one byte slot
  typedef struct packed {
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
    logic             high;
  } selCtl_t;

  localparam int SEL_CTL_W = $bits(selCtl_t);

endpackage

// File: rtl/simd_part_mul_pipe.sv
module simd_part_mul_pipe #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dOut = dIn;
    end else begin : g_regs
      localparam int CNT_W = $clog2(STAGES + 1) + 1;

      logic [WIDTH-1:0] stageQ [STAGES];
      logic             pastValid;
      logic [WIDTH-1:0] prevIn;
      logic [CNT_W-1:0] holdCnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
        end else begin
          stageQ[0] <= dIn;
          for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
        end
      end

      assign dOut = stageQ[STAGES-1];

      // checker state: how long the input has held still
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pastValid <= 1'b0;
          prevIn    <= '0;
          holdCnt   <= '0;
        end else begin
          pastValid <= 1'b1;
          prevIn    <= dIn;
          if (dIn != prevIn)                  holdCnt <= '0;
          else if (holdCnt != CNT_W'(STAGES)) holdCnt <= holdCnt + 1'b1;
        end
      end

      // R9: an input held for STAGES+1 samples has reached the output
      a_r9_settles: assert property (@(posedge clk) disable iff (!rst_n)
        ((holdCnt >= CNT_W'(STAGES - 1)) && (dIn == prevIn)) |-> (dOut == dIn));

      // R10: the first edge after reset still shows cleared levels
      a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pastValid |-> (dOut == '0));
    end
  endgenerate

endmodule

// File: rtl/simd_part_mul_ctrl.sv
module simd_part_mul_ctrl
  import simd_part_mul_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANE_SLOTS-2:0]      laneCuts,
  input  logic [OP_W*LANE_SLOTS-1:0] laneOps,
  output arrCtl_t [LANE_SLOTS-1:0]   arrCtl,
  output selCtl_t [LANE_SLOTS-1:0]   selCtlLate
);

  logic [IDX_W-1:0]        loIdx [LANE_SLOTS];
  logic [IDX_W-1:0]        hiIdx [LANE_SLOTS];
  selCtl_t [LANE_SLOTS-1:0] selCtlNow;

  // lane bounds for each byte slot
  always_comb begin
    logic [IDX_W-1:0] cur;
    cur      = '0;
    loIdx[0] = '0;
    for (int k = 1; k < LANE_SLOTS; k++) begin
      if (laneCuts[k-1]) cur = IDX_W'(k);
      loIdx[k] = cur;
    end
    cur                 = IDX_W'(LANE_SLOTS - 1);
    hiIdx[LANE_SLOTS-1] = cur;
    for (int k = LANE_SLOTS - 2; k >= 0; k--) begin
      if (laneCuts[k]) cur = IDX_W'(k);
      hiIdx[k] = cur;
    end
  end

  // operation of the lane, read from its lowest byte
  always_comb begin
    laneOp_e op;
    for (int k = 0; k < LANE_SLOTS; k++) begin
      op = laneOp_e'(laneOps[int'(loIdx[k])*OP_W +: OP_W]);
      arrCtl[k].lo      = loIdx[k];
      arrCtl[k].hi      = hiIdx[k];
      arrCtl[k].aSgn    = (op != OP_HI_UU);
      arrCtl[k].bSgn    = (op == OP_LOW) || (op == OP_HI_SS);
      selCtlNow[k].lo   = loIdx[k];
      selCtlNow[k].hi   = hiIdx[k];
      selCtlNow[k].high = (op != OP_LOW);
    end
  end

  simd_part_mul_pipe #(
    .WIDTH (SEL_CTL_W * LANE_SLOTS),
    .STAGES(STAGES)
  ) u_ctlPipe (
    .clk  (clk),
    .rst_n(rst_n),
    .dIn  (selCtlNow),
    .dOut (selCtlLate)
  );

  generate
    for (genvar k = 0; k < LANE_SLOTS; k++) begin : g_chk
      // R7: every byte of a lane carries the strobes of its lowest byte
      a_r7_lane_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (selCtlNow[k].high == selCtlNow[loIdx[k]].high) &&
        (arrCtl[k].aSgn == arrCtl[loIdx[k]].aSgn) &&
        (arrCtl[k].bSgn == arrCtl[loIdx[k]].bSgn));
    end
  endgenerate

endmodule

// File: rtl/simd_part_mul_array.sv
module simd_part_mul_array
  import simd_part_mul_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  input  arrCtl_t [LANE_SLOTS-1:0] ctl,
  output logic [WIDE_W-1:0]        wideOut
);

  logic [BYTE_W-1:0]     aB   [LANE_SLOTS];
  logic [BYTE_W-1:0]     bB   [LANE_SLOTS];
  logic [BYTE_W-1:0]     negA [LANE_SLOTS];
  logic [BYTE_W-1:0]     negB [LANE_SLOTS];
  logic [PROD_W-1:0]     prodP [LANE_SLOTS][LANE_SLOTS];
  logic [LANE_SLOTS-1:0] aNeg, bNeg;
  logic [WIDE_SLOTS-1:0] fieldStart;
  logic [WIDE_W-1:0]     ppSum, corrA, corrB, partSum;

  // add two vectors with no carry across a product field start
  function automatic logic [WIDE_W-1:0] fieldAdd(
    input logic [WIDE_W-1:0]     x,
    input logic [WIDE_W-1:0]     y,
    input logic [WIDE_SLOTS-1:0] starts
  );
    logic [WIDE_W-1:0] r;
    logic [BYTE_W:0]   s;
    logic              c;
    c = 1'b0;
    for (int t = 0; t < WIDE_SLOTS; t++) begin
      s = {1'b0, x[t*BYTE_W +: BYTE_W]} + {1'b0, y[t*BYTE_W +: BYTE_W]}
        + {{BYTE_W{1'b0}}, (starts[t] ? 1'b0 : c)};
      r[t*BYTE_W +: BYTE_W] = s[BYTE_W-1:0];
      c = s[BYTE_W];
    end
    return r;
  endfunction

  always_comb begin
    for (int k = 0; k < LANE_SLOTS; k++) begin
      aB[k] = opA[k*BYTE_W +: BYTE_W];
      bB[k] = opB[k*BYTE_W +: BYTE_W];
    end
  end

  // shared byte-by-byte partial product array
  always_comb begin
    for (int i = 0; i < LANE_SLOTS; i++)
      for (int j = 0; j < LANE_SLOTS; j++)
        prodP[i][j] = PROD_W'(aB[i]) * PROD_W'(bB[j]);
  end

  // unsigned lane products: only pairs from the same lane contribute
  always_comb begin
    ppSum = '0;
    for (int i = 0; i < LANE_SLOTS; i++)
      for (int j = 0; j < LANE_SLOTS; j++)
        if (ctl[i].lo == ctl[j].lo)
          ppSum = ppSum + (WIDE_W'(prodP[i][j]) << (BYTE_W * (i + j)));
  end

  // lane-wise two's-complement negation of each operand
  always_comb begin
    logic carA, carB, cinA, cinB;
    carA = 1'b0;
    carB = 1'b0;
    for (int k = 0; k < LANE_SLOTS; k++) begin
      cinA = (ctl[k].lo == IDX_W'(k)) ? 1'b1 : carA;
      cinB = (ctl[k].lo == IDX_W'(k)) ? 1'b1 : carB;
      {carA, negA[k]} = {1'b0, ~aB[k]} + {{BYTE_W{1'b0}}, cinA};
      {carB, negB[k]} = {1'b0, ~bB[k]} + {{BYTE_W{1'b0}}, cinB};
    end
  end

  // sign corrections sit in the upper half of each lane's product field
  always_comb begin
    int tgt;
    corrA = '0;
    corrB = '0;
    for (int k = 0; k < LANE_SLOTS; k++) begin
      aNeg[k] = ctl[k].aSgn & opA[int'(ctl[k].hi)*BYTE_W + BYTE_W - 1];
      bNeg[k] = ctl[k].bSgn & opB[int'(ctl[k].hi)*BYTE_W + BYTE_W - 1];
      tgt = int'(ctl[k].hi) + 1 + k;
      if (aNeg[k]) corrA[tgt*BYTE_W +: BYTE_W] = negB[k];
      if (bNeg[k]) corrB[tgt*BYTE_W +: BYTE_W] = negA[k];
    end
  end

  always_comb begin
    for (int m = 0; m < LANE_SLOTS; m++) begin
      fieldStart[2*m]   = (ctl[m].lo == IDX_W'(m));
      fieldStart[2*m+1] = 1'b0;
    end
  end

  assign partSum = fieldAdd(ppSum, corrA, fieldStart);
  assign wideOut = fieldAdd(partSum, corrB, fieldStart);

  // R2: a zero operand gives zero in every product field
  a_r2_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (opA == '0) |-> (wideOut == '0));
  a_r2_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (opB == '0) |-> (wideOut == '0));

endmodule

// File: rtl/simd_part_mul_select.sv
module simd_part_mul_select
  import simd_part_mul_pkg::*;
(
  input  logic [WIDE_W-1:0]        interIn,
  input  selCtl_t [LANE_SLOTS-1:0] ctl,
  output logic [DATA_W-1:0]        resOut
);

  // byte k takes field byte lo+k (low half) or hi+1+k (high half)
  always_comb begin
    int src;
    resOut = '0;
    for (int k = 0; k < LANE_SLOTS; k++) begin
      src = ctl[k].high ? (int'(ctl[k].hi) + 1 + k) : (int'(ctl[k].lo) + k);
      resOut[k*BYTE_W +: BYTE_W] = interIn[src*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/simd_part_mul.sv
module simd_part_mul
  import simd_part_mul_pkg::*;
#(
  parameter int PIPE_STAGES = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W-1:0]          opA,
  input  logic [DATA_W-1:0]          opB,
  input  logic [LANE_SLOTS-2:0]      laneCuts,
  input  logic [OP_W*LANE_SLOTS-1:0] laneOps,
  output logic [DATA_W-1:0]          prodOut,
  output logic [WIDE_W-1:0]          wideOut
);

  arrCtl_t [LANE_SLOTS-1:0] arrCtl;
  selCtl_t [LANE_SLOTS-1:0] selCtlLate;
  logic [WIDE_W-1:0]        wideNow;

  simd_part_mul_ctrl #(.STAGES(PIPE_STAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .laneCuts  (laneCuts),
    .laneOps   (laneOps),
    .arrCtl    (arrCtl),
    .selCtlLate(selCtlLate)
  );

  simd_part_mul_array u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .opA    (opA),
    .opB    (opB),
    .ctl    (arrCtl),
    .wideOut(wideNow)
  );

  simd_part_mul_pipe #(
    .WIDTH (WIDE_W),
    .STAGES(PIPE_STAGES)
  ) u_widePipe (
    .clk  (clk),
    .rst_n(rst_n),
    .dIn  (wideNow),
    .dOut (wideOut)
  );

  simd_part_mul_select u_select (
    .interIn(wideOut),
    .ctl    (selCtlLate),
    .resOut (prodOut)
  );

endmodule

// File: tb/simd_part_mul_tb.sv
`timescale 1ns/1ps
module simd_part_mul_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [63:0]  a, b;
  logic [6:0]   cuts;
  logic [15:0]  ops;
  logic [63:0]  resP, resC;
  logic [127:0] wideP, wideC;

  always #4 clk = ~clk;

  simd_part_mul #(.PIPE_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .opA(a), .opB(b), .laneCuts(cuts),
    .laneOps(ops), .prodOut(resP), .wideOut(wideP));

  simd_part_mul #(.PIPE_STAGES(0)) comb_i (
    .clk(clk), .rst_n(rst_n), .opA(a), .opB(b), .laneCuts(cuts),
    .laneOps(ops), .prodOut(resC), .wideOut(wideC));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [63:0]  hRes  [2];
  logic [127:0] hWide [2];
  int hCount = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  function automatic logic [63:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // arithmetic model of the requirements
  task automatic refMul(input logic [63:0] ia, input logic [63:0] ib,
                        input logic [6:0] ic, input logic [15:0] io,
                        output logic [63:0] res, output logic [127:0] wide);
    int lo = 0;
    res  = '0;
    wide = '0;
    for (int k = 0; k < 8; k++) begin
      if (k == 7 || ic[k]) begin
        int w, s;
        logic [1:0]   op;
        logic [127:0] mw, m2w, ap, bp, pr, half;
        w   = 8 * (k - lo + 1);
        s   = 8 * lo;
        op  = io[2*lo +: 2];
        mw  = (128'd1 << w) - 128'd1;
        m2w = (128'd1 << (2*w)) - 128'd1;
        ap  = (128'(ia) >> s) & mw;
        bp  = (128'(ib) >> s) & mw;
        if (op != 2'd3 && ap[w-1]) ap = ap | ~mw;
        if (op <  2'd2 && bp[w-1]) bp = bp | ~mw;
        pr   = (ap * bp) & m2w;
        wide = wide | (pr << (2*s));
        half = (op == 2'd0) ? (pr & mw) : ((pr >> w) & mw);
        res  = res | 64'(half << s);
        lo = k + 1;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [63:0] ia, input logic [63:0] ib,
                      input logic [6:0] ic, input logic [15:0] io, input string tag);
    logic [63:0]  er;
    logic [127:0] ew;
    @(negedge clk);
    if (hCount >= 2) begin
      chk("R9 prodOut two edges later", 128'(resP), 128'(hRes[1]));
      chk("R9 wideOut two edges later", wideP, hWide[1]);
    end
    a = ia; b = ib; cuts = ic; ops = io;
    refMul(ia, ib, ic, io, er, ew);
    #1;
    chk({tag, " R8 prodOut"}, 128'(resC), 128'(er));
    chk("R1 R2 R8 wideOut", wideC, ew);
    hRes[1]  = hRes[0];  hWide[1] = hWide[0];
    hRes[0]  = er;       hWide[0] = ew;
    hCount++;
  endtask

  function automatic void pickPair(input int p, output logic [63:0] pa, output logic [63:0] pb);
    case (p)
      0: begin pa = 64'h0123456789ABCDEF; pb = 64'hFEDCBA9876543210; end
      1: begin pa = 64'h8123456789ABCDEF; pb = 64'hFEDCBA9876543210; end
      2: begin pa = 64'h8080808080808080; pb = 64'h8080808080808080; end
      3: begin pa = 64'hFFFFFFFFFFFFFFFF; pb = 64'h7F7F7F7F7F7F7F7F; end
      4: begin pa = 64'hFFFFFFFFFFFFFFFF; pb = 64'hFFFFFFFFFFFFFFFF; end
      default: begin pa = 64'h7F7F7F7F7F7F7F7F; pb = 64'h8080808080808080; end
    endcase
  endfunction

  initial begin
    logic [63:0] pa, pb;
    logic [15:0] uni, junk, keep;
    string       tg;
    rst_n = 1'b0;
    a = 64'hDEADBEEFCAFEF00D; b = 64'h0123456789ABCDEF;
    cuts = 7'h55; ops = 16'h1B1B;
    repeat (3) begin
      @(negedge clk);
      chk("R10 prodOut in reset", 128'(resP), 128'd0);
      chk("R10 wideOut in reset", wideP, 128'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // every cut pattern under every uniform code
    for (int c = 0; c < 128; c++) begin
      for (int o = 0; o < 4; o++) begin
        uni = {8{2'(o)}};
        case (o)
          0: tg = "R3";
          1: tg = "R4";
          2: tg = "R5";
          default: tg = "R6";
        endcase
        for (int p = 0; p < 6; p++) begin
          pickPair(p, pa, pb);
          step(pa, pb, 7'(c), uni, tg);
        end
      end
    end

    // mixed codes and operands changing every cycle
    for (int n = 0; n < 600; n++) begin
      pa = nextRand(); pb = nextRand();
      step(pa, pb, 7'(nextRand()), 16'(nextRand()), "R1 mixed");
    end

    // codes of non-lowest bytes must not matter
    for (int n = 0; n < 200; n++) begin
      logic [6:0] rc;
      pa = nextRand(); pb = nextRand();
      rc = 7'(nextRand());
      uni = 16'(nextRand());
      keep = '0;
      for (int k = 0; k < 8; k++)
        if (k == 0 || rc[k-1]) keep[2*k +: 2] = 2'b11;
      step(pa, pb, rc, uni, "R7 base");
      junk = (uni & keep) | (16'(nextRand()) & ~keep);
      step(pa, pb, rc, junk, "R7 other-byte codes");
    end

    step(64'd0, 64'd0, 7'd0, 16'd0, "R3 flush");
    step(64'd0, 64'd0, 7'd0, 16'd0, "R3 flush");
    step(64'd0, 64'd0, 7'd0, 16'd0, "R3 flush");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule